// File: doc/BRIEF.md
# Row Stream Address Sequencer

This block sequences the memory traffic of a row-at-a-time filter accelerator. Software sets three element-indexed base offsets (input matrix, output matrix, coefficient vector) and the matrix shape through a small write-only register port. A start pulse captures these settings. The block then produces two independent request streams against one word-addressed memory. The read stream fetches the coefficient vector followed by one input row. The write stream drains the matching output row, which is shorter than the input row by the filter length minus one.

The two streams are decoupled. The read side may fetch row r+1 while the write side is still storing row r. That gives the two-deep row buffering a load/compute/store pipeline needs. Each request channel is a valid/ready pair carrying an element address. The block holds a request until it is accepted. It steps to the next element on every accepted beat, so a channel that is never stalled gets one element per cycle within a burst. The filter arithmetic, the row storage and any bus bridging live outside this block.

Top module: `rowseq_top`

## Requirements
- R1: While reset is asserted and right after it, `rdValid`, `wrValid`, `done` and `busy` are all low.
- R2: A `start` pulse seen while idle captures every programmed register into the job. Register writes made during a job have no effect on its addresses. A `start` seen while busy is ignored.
- R3: For each row r in ascending order, the read stream issues `TAPS` addresses `tapBase+t` (t ascending), then `nCols` addresses `inBase + r*nCols + j` (j ascending).
- R4: For each row r in ascending order, the write stream issues `outLen` addresses `outBase + r*outLen + j` (j ascending), with `outLen = nCols - TAPS + 1`.
- R5: A request whose ready is low keeps its valid high and its address unchanged in the next cycle.
- R6: The channels are independent. Reads of row r+1 proceed while the write channel is stalled on row r, and reads and writes may both be accepted in the same cycle.
- R7: No write of row r is issued before all reads of row r are accepted. No read of row r+2 is issued before all writes of row r are accepted.
- R8: When `nCols < TAPS`, no write is ever issued, all reads are still issued, and `done` still rises.
- R9: `done` rises once the final output element is accepted, and stays high until the next accepted `start`. With `nRows = 0`, `done` rises and no request is issued. No request is issued while `busy` is low.
- R10: Register port map by `regAddr`: 0 input base, 1 output base, 2 coefficient base, 3 row count (low `DIM_W` bits), 4 column count (low `DIM_W` bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select |
| regWdata | input | ADDR_W | Register write data |
| start | input | 1 | Job start pulse |
| rdValid | output | 1 | Read request valid |
| rdReady | input | 1 | Read request accepted |
| rdAddr | output | ADDR_W | Read element address |
| wrValid | output | 1 | Write request valid |
| wrReady | input | 1 | Write request accepted |
| wrAddr | output | ADDR_W | Write element address |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job finished |

## Verification
The bench targets the row-stride mismatch. A sequencer that advanced the output base by the input row length would write into gaps, and the scoreboard shows this at the first write of row 1. It holds write-ready low until reads stop, to confirm that reads run exactly one row ahead: a design without the limit would overrun the row buffer, and one without decoupling would stall reads as well. It also runs jobs with fewer columns than coefficients and with zero rows; a wrong design would underflow the output length into a huge burst or never raise `done`. Random ready patterns catch addresses that move while stalled, and a mid-job reprogram with a stray `start` catches a design that does not capture its parameters.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;

  localparam logic [2:0] REG_IN_BASE  = 3'd0;
  localparam logic [2:0] REG_OUT_BASE = 3'd1;
  localparam logic [2:0] REG_TAP_BASE = 3'd2;
  localparam logic [2:0] REG_ROWS     = 3'd3;
  localparam logic [2:0] REG_COLS     = 3'd4;

  typedef enum logic [1:0] {RD_IDLE, RD_TAPS, RD_ROW} rdState_t;
  typedef enum logic       {WR_IDLE, WR_ROW}          wrState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic latch;
    logic rdTapSel;
    logic rdAdv;
    logic rdTapsEnd;
    logic rdRowEnd;
    logic wrAdv;
    logic wrRowEnd;
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic tapLast;
    logic colLast;
    logic colsZero;
    logic rdRowsLeft;
    logic rdRoom;
    logic wrRowReady;
    logic outLast;
    logic outEmpty;
    logic allWritten;
  } seqStatus_t;

endpackage

// File: rtl/rowseq_datapath.sv
module rowseq_datapath
  import rowseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 8,
  parameter int TAPS   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [ADDR_W-1:0] regWdata,
  input  seqStrobe_t        strb,
  output seqStatus_t        st,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr
);

  localparam logic [DIM_W-1:0] TAP_CNT = DIM_W'(TAPS);
  localparam logic [DIM_W-1:0] DIM_ONE = DIM_W'(1);
  localparam logic [DIM_W-1:0] DIM_TWO = DIM_W'(2);

  logic [ADDR_W-1:0] progInBase, progOutBase, progTapBase;
  logic [DIM_W-1:0]  progRows, progCols;

  logic [ADDR_W-1:0] actTapBase;
  logic [DIM_W-1:0]  actRows, actCols, actOutLen;

  logic [ADDR_W-1:0] rdRowBase, wrRowBase;
  logic [DIM_W-1:0]  rdIdx, rdRow, wrIdx, wrRow;
  logic [DIM_W-1:0]  progOutLen;

  assign progOutLen = (progCols >= TAP_CNT) ? (progCols - TAP_CNT + DIM_ONE) : '0;

  // programmable registers, writable at any time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progInBase  <= '0;
      progOutBase <= '0;
      progTapBase <= '0;
      progRows    <= '0;
      progCols    <= '0;
    end else if (regWe) begin
      case (regAddr)
        REG_IN_BASE:  progInBase  <= regWdata;
        REG_OUT_BASE: progOutBase <= regWdata;
        REG_TAP_BASE: progTapBase <= regWdata;
        REG_ROWS:     progRows    <= regWdata[DIM_W-1:0];
        REG_COLS:     progCols    <= regWdata[DIM_W-1:0];
        default: ;
      endcase
    end
  end

  // job copy and address counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actTapBase <= '0;
      actRows    <= '0;
      actCols    <= '0;
      actOutLen  <= '0;
      rdRowBase  <= '0;
      wrRowBase  <= '0;
      rdIdx      <= '0;
      rdRow      <= '0;
      wrIdx      <= '0;
      wrRow      <= '0;
    end else if (strb.latch) begin
      actTapBase <= progTapBase;
      actRows    <= progRows;
      actCols    <= progCols;
      actOutLen  <= progOutLen;
      rdRowBase  <= progInBase;
      wrRowBase  <= progOutBase;
      rdIdx      <= '0;
      rdRow      <= '0;
      wrIdx      <= '0;
      wrRow      <= '0;
    end else begin
      if (strb.rdAdv) rdIdx <= rdIdx + DIM_ONE;
      if (strb.rdTapsEnd) rdIdx <= '0;
      if (strb.rdRowEnd) begin
        rdIdx     <= '0;
        rdRow     <= rdRow + DIM_ONE;
        rdRowBase <= rdRowBase + ADDR_W'(actCols);
      end
      if (strb.wrAdv) wrIdx <= wrIdx + DIM_ONE;
      if (strb.wrRowEnd) begin
        wrIdx     <= '0;
        wrRow     <= wrRow + DIM_ONE;
        wrRowBase <= wrRowBase + ADDR_W'(actOutLen);
      end
    end
  end

  always_comb begin
    st.tapLast    = (rdIdx == TAP_CNT - DIM_ONE);
    st.colLast    = (rdIdx == actCols - DIM_ONE);
    st.colsZero   = (actCols == '0);
    st.rdRowsLeft = (rdRow < actRows);
    st.rdRoom     = ((rdRow - wrRow) < DIM_TWO);
    st.wrRowReady = (wrRow < rdRow);
    st.outLast    = (wrIdx == actOutLen - DIM_ONE);
    st.outEmpty   = (actOutLen == '0);
    st.allWritten = (wrRow == actRows);
  end

  assign rdAddr = strb.rdTapSel ? (actTapBase + ADDR_W'(rdIdx)) : (rdRowBase + ADDR_W'(rdIdx));
  assign wrAddr = wrRowBase + ADDR_W'(wrIdx);

  AST_WR_NOT_AHEAD: assert property (@(posedge clk) disable iff (!rstN)
    wrRow <= rdRow);  // R7

endmodule

// File: rtl/rowseq_ctrl.sv
module rowseq_ctrl
  import rowseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  seqStatus_t st,
  input  logic       rdReady,
  input  logic       wrReady,
  output seqStrobe_t strb,
  output logic       rdValid,
  output logic       wrValid,
  output logic       busy,
  output logic       done
);

  rdState_t rdState, rdNext;
  wrState_t wrState, wrNext;

  always_comb begin
    strb          = '0;
    rdValid       = 1'b0;
    wrValid       = 1'b0;
    rdNext        = rdState;
    wrNext        = wrState;
    strb.latch    = start && !busy;
    strb.rdTapSel = (rdState == RD_TAPS);
    if (busy) begin
      case (rdState)
        RD_IDLE: if (st.rdRowsLeft && st.rdRoom) rdNext = RD_TAPS;
        RD_TAPS: begin
          rdValid = 1'b1;
          if (rdReady) begin
            if (st.tapLast) begin
              strb.rdTapsEnd = 1'b1;
              rdNext = RD_ROW;
            end else strb.rdAdv = 1'b1;
          end
        end
        RD_ROW: begin
          if (st.colsZero) begin
            strb.rdRowEnd = 1'b1;
            rdNext = RD_IDLE;
          end else begin
            rdValid = 1'b1;
            if (rdReady) begin
              if (st.colLast) begin
                strb.rdRowEnd = 1'b1;
                rdNext = RD_IDLE;
              end else strb.rdAdv = 1'b1;
            end
          end
        end
        default: rdNext = RD_IDLE;
      endcase
      case (wrState)
        WR_IDLE: if (st.wrRowReady) wrNext = WR_ROW;
        WR_ROW: begin
          if (st.outEmpty) begin
            strb.wrRowEnd = 1'b1;
            wrNext = WR_IDLE;
          end else begin
            wrValid = 1'b1;
            if (wrReady) begin
              if (st.outLast) begin
                strb.wrRowEnd = 1'b1;
                wrNext = WR_IDLE;
              end else strb.wrAdv = 1'b1;
            end
          end
        end
        default: wrNext = WR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdState <= RD_IDLE;
      wrState <= WR_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      rdState <= rdNext;
      wrState <= wrNext;
      if (strb.latch) begin
        busy <= 1'b1;
        done <= 1'b0;
      end else if (busy && st.allWritten && wrState == WR_IDLE) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !rdReady |=> rdValid);  // R5
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrReady |=> wrValid);  // R5
  AST_WR_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> st.wrRowReady);  // R7
  AST_RD_ROW_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> st.rdRoom);  // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !rdValid && !wrValid);  // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);  // R9

endmodule

// File: rtl/rowseq_top.sv
module rowseq_top
  import rowseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 8,
  parameter int TAPS   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic              start,
  output logic              rdValid,
  input  logic              rdReady,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              busy,
  output logic              done
);

  seqStrobe_t strb;
  seqStatus_t st;

  rowseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .st(st),
    .rdReady(rdReady), .wrReady(wrReady), .strb(strb),
    .rdValid(rdValid), .wrValid(wrValid), .busy(busy), .done(done)
  );

  rowseq_datapath #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .TAPS(TAPS)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .strb(strb), .st(st),
    .rdAddr(rdAddr), .wrAddr(wrAddr)
  );

  AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !rdReady |=> $stable(rdAddr));  // R5
  AST_WR_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrReady |=> $stable(wrAddr));  // R5

endmodule

// File: tb/rowseq_top_tb.sv
`timescale 1ns/1ps
module rowseq_top_tb;
  localparam int ADDR_W = 16;
  localparam int DIM_W  = 8;
  localparam int TAPS   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [ADDR_W-1:0] regWdata = '0;
  logic start = 1'b0;
  logic rdReady = 1'b0, wrReady = 1'b0;
  logic rdValid, wrValid, busy, done;
  logic [ADDR_W-1:0] rdAddr, wrAddr;

  always #5 clk = ~clk;

  rowseq_top #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .TAPS(TAPS)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .start(start), .rdValid(rdValid), .rdReady(rdReady), .rdAddr(rdAddr),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .busy(busy), .done(done)
  );

  int nChecks = 0, nFails = 0;
  logic [ADDR_W-1:0] rdQ[$], wrQ[$];
  int rdMode = 0, wrMode = 0;  // 0 always ready, 1 random, 2 held low
  int rdHs = 0, wrHs = 0, jobCols = 0, jobOut = 0;
  logic prevRdStall = 1'b0, prevWrStall = 1'b0;
  logic [ADDR_W-1:0] prevRdAddr = '0, prevWrAddr = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic pickReady(input int mode);
    if (mode == 0) return 1'b1;
    if (mode == 2) return 1'b0;
    return ($urandom % 4) != 0;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    logic nr, nw;
    logic [ADDR_W-1:0] e;
    nr = pickReady(rdMode);
    nw = pickReady(wrMode);
    if (prevRdStall) chk(rdValid && rdAddr == prevRdAddr, "R5 read hold", {rdValid, rdAddr}, {1'b1, prevRdAddr});
    if (prevWrStall) chk(wrValid && wrAddr == prevWrAddr, "R5 write hold", {wrValid, wrAddr}, {1'b1, prevWrAddr});
    rdReady = nr;
    wrReady = nw;
    if (wrValid && nw) begin
      if (jobOut > 0) chk(wrHs / jobOut < rdHs / (TAPS + jobCols), "R7 write before row read",
                          wrHs / jobOut, rdHs / (TAPS + jobCols));
      if (wrQ.size() == 0) chk(0, "R4 unexpected write", wrAddr, 0);
      else begin
        e = wrQ.pop_front();
        chk(wrAddr == e, "R4 R10 write address", wrAddr, e);
      end
      wrHs++;
    end
    if (rdValid && nr) begin
      if (jobOut > 0) chk(rdHs / (TAPS + jobCols) < wrHs / jobOut + 2, "R7 read too far ahead",
                          rdHs / (TAPS + jobCols), wrHs / jobOut + 2);
      if (rdQ.size() == 0) chk(0, "R3 unexpected read", rdAddr, 0);
      else begin
        e = rdQ.pop_front();
        chk(rdAddr == e, "R3 R10 read address", rdAddr, e);
      end
      rdHs++;
    end
    prevRdStall = rdValid && !nr;
    prevRdAddr  = rdAddr;
    prevWrStall = wrValid && !nw;
    prevWrAddr  = wrAddr;
  end

  task automatic regWrite(input logic [2:0] a, input logic [ADDR_W-1:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic startJob(input int inB, input int outB, input int tapB, input int rows, input int cols);
    int ol;
    ol = (cols >= TAPS) ? cols - TAPS + 1 : 0;
    regWrite(3'd0, ADDR_W'(inB));
    regWrite(3'd1, ADDR_W'(outB));
    regWrite(3'd2, ADDR_W'(tapB));
    regWrite(3'd3, ADDR_W'(rows));
    regWrite(3'd4, ADDR_W'(cols));
    rdQ.delete(); wrQ.delete();
    for (int r = 0; r < rows; r++) begin
      for (int t = 0; t < TAPS; t++) rdQ.push_back(ADDR_W'(tapB + t));
      for (int j = 0; j < cols; j++) rdQ.push_back(ADDR_W'(inB + r * cols + j));
      for (int j = 0; j < ol; j++) wrQ.push_back(ADDR_W'(outB + r * ol + j));
    end
    rdHs = 0; wrHs = 0; jobCols = cols; jobOut = ol;
    pulseStart();
    chk(busy && !done, "R9 done cleared by start", {busy, done}, 2'b10);
  endtask

  task automatic finishJob(input int rows, input string tag);
    int n;
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done, {tag, " done rises"}, done, 1);
    repeat (3) @(negedge clk);
    chk(rdQ.size() == 0 && wrQ.size() == 0, {tag, " all expected requests seen"},
        rdQ.size() + wrQ.size(), 0);
    chk(rdHs == rows * (TAPS + jobCols), {tag, " read count"}, rdHs, rows * (TAPS + jobCols));
    chk(wrHs == rows * jobOut, {tag, " write count"}, wrHs, rows * jobOut);
    chk(done && !busy, "R9 done holds", {done, busy}, 2'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rdValid && !wrValid && !done && !busy, "R1 outputs during reset",
        {rdValid, wrValid, done, busy}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!rdValid && !wrValid && !done && !busy, "R1 outputs after reset",
        {rdValid, wrValid, done, busy}, 0);

    // basic job, free-flowing channels
    rdMode = 0; wrMode = 0;
    startJob(16'h0100, 16'h0400, 16'h0040, 3, 6);
    finishJob(3, "R3 R4 basic");

    // random stalls on both channels
    rdMode = 1; wrMode = 1;
    startJob(16'h1000, 16'h2000, 16'h0030, 5, 9);
    finishJob(5, "R5 random stalls");

    // write channel blocked: reads run exactly one row ahead
    rdMode = 0; wrMode = 2;
    startJob(16'h0200, 16'h0800, 16'h0010, 4, 5);
    begin
      int n;
      n = 0;
      while (rdHs < 2 * (TAPS + 5) && n < 1000) begin
        @(negedge clk);
        n++;
      end
      chk(rdHs == 2 * (TAPS + 5), "R6 reads of next row while writes stalled", rdHs, 2 * (TAPS + 5));
      repeat (12) @(negedge clk);
      chk(rdHs == 2 * (TAPS + 5) && !rdValid, "R7 no read of row two ahead", rdHs, 2 * (TAPS + 5));
      chk(wrValid && wrHs == 0, "R6 write waiting", {wrValid, 8'(wrHs)}, 9'h100);
    end
    wrMode = 0;
    finishJob(4, "R6 R7 blocked writes");

    // fewer columns than coefficients
    rdMode = 1; wrMode = 0;
    startJob(16'h0300, 16'h0900, 16'h0020, 3, 2);
    finishJob(3, "R8 short rows");

    // exactly TAPS columns: one output per row
    startJob(16'h0310, 16'h0a00, 16'h0020, 3, TAPS);
    finishJob(3, "R4 single output per row");

    // zero rows
    rdMode = 0;
    startJob(16'h0000, 16'h0000, 16'h0000, 0, 7);
    finishJob(0, "R9 zero rows");

    // reprogram and stray start mid-job
    rdMode = 1; wrMode = 1;
    startJob(16'h0500, 16'h0600, 16'h0050, 2, 8);
    repeat (4) @(negedge clk);
    regWrite(3'd3, 16'd7);
    regWrite(3'd0, 16'h0999);
    regWrite(3'd4, 16'd3);
    pulseStart();
    finishJob(2, "R2 parameters captured");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule